// File: doc/BRIEF.md
# RS-485 Driver-Enable Turnaround Controller

This block sets the direction of a half-duplex RS-485 line for a UART transmitter. One of the two modem-control output pins is repurposed as the transceiver's driver enable. The pin goes to transmit as soon as the serializer reports that it is busy. It stays there while characters are sent back to back. After the final stop bit of the last queued character, it keeps driving for a programmable number of bit times and then returns the transceiver to receive.

The hold length is a 4-bit field, covering 0 to 15 bit times. It is written through the register port at the address that reads as modem status, so the field is write-only. A write updates it only while the enhanced-function enable is set. When the automatic direction feature is off, both pins simply follow their software-controlled modem-control bits.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: After reset the hold delay is 0, the direction state is receive, and with the software bits low both pins read 0, including right after the auto-direction feature is enabled.
- R2: With auto-direction enabled, `txBusy` sampled high at a clock edge drives the selected direction pin to 1 from the following cycle.
- R3: With a delay N of 1 to 15, once `stopDone` is sampled with `fifoEmpty` high, the pin stays 1 through N `bitTick` pulses and drops to 0 in the cycle after the Nth pulse. Ticks that arrive while a character is still being sent do not count.
- R4: With a delay of 0, the pin drops to 0 in the cycle after the `stopDone` pulse whenever `fifoEmpty` is high.
- R5: A `stopDone` pulse while `fifoEmpty` is low leaves the pin at 1 and starts no hold.
- R6: `txBusy` rising during a hold cancels it. The pin stays at 1, and after the next final stop a full hold of N ticks applies again.
- R7: A write with `regWrEn` high, `regAddr` equal to 6 and `cfgEnhanced` high loads `regWrData[7:4]` as the delay. Bits [3:0] are ignored.
- R8: A write while `cfgEnhanced` is low, or to any other address, leaves the delay unchanged.
- R9: With `cfgAutoDir` low, `rtsPin` equals `swRts` and `dtrPin` equals `swDtr`. Clearing `cfgAutoDir` during transmission returns the direction state to receive.
- R10: `selDtr` = 0 routes the direction to `rtsPin` and leaves `dtrPin` on `swDtr`. `selDtr` = 1 routes it to `dtrPin` and leaves `rtsPin` on `swRts`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bitTick | input | 1 | One-cycle pulse per bit time from the baud generator |
| txBusy | input | 1 | Serializer is sending a character |
| stopDone | input | 1 | One-cycle pulse at the end of a character's stop bit |
| fifoEmpty | input | 1 | Transmit FIFO holds no further character |
| cfgAutoDir | input | 1 | Enables automatic direction control |
| cfgEnhanced | input | 1 | Enhanced-function enable; gates delay writes |
| selDtr | input | 1 | 0: direction on rtsPin, 1: direction on dtrPin |
| swRts | input | 1 | Software RTS modem-control bit |
| swDtr | input | 1 | Software DTR modem-control bit |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register write address |
| regWrData | input | 8 | Register write data |
| rtsPin | output | 1 | RTS output, 1 = driver enabled when it carries the direction |
| dtrPin | output | 1 | DTR output, 1 = driver enabled when it carries the direction |

## Verification
Every result is due one clock after the edge that samples its cause. The direction state is the only register between the inputs and the pins, so `txBusy`, the final `stopDone` and the last hold tick each show on the pin one cycle later. The pin-routing and software-bit paths are combinational and show in the same cycle. The bench drives inputs on the falling edge and samples on the next falling edge, half a period after the register updated. The hold is checked after every tick pulse, so a hold that is one tick short or one tick long shows up at the exact pulse where it goes wrong.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;
  typedef enum logic [1:0] {
    DIR_IDLE = 2'd0,
    DIR_TX   = 2'd1,
    DIR_HOLD = 2'd2
  } dirState_e;

  typedef struct packed {
    logic loadHold;
    logic decHold;
  } holdStrobe_t;
endpackage

// File: rtl/rs485_dir_dp.sv
module rs485_dir_dp
  import rs485_dir_pkg::*;
#(
  parameter int DELAY_W  = 4,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  parameter int DLY_ADDR = 6,
  parameter int DLY_LSB  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              cfgEnhanced,
  input  holdStrobe_t       strobe,
  output logic              delayZero,
  output logic              holdLast,
  output logic              holdNonZero
);
  localparam int DLY_MSB = DLY_LSB + DELAY_W - 1;
  localparam logic [ADDR_W-1:0] ADDR_MATCH = ADDR_W'(DLY_ADDR);
  localparam logic [DELAY_W-1:0] ONE = DELAY_W'(1);

  logic [DELAY_W-1:0] delayReg;
  logic [DELAY_W-1:0] holdCnt;
  logic               wrHit;

  assign wrHit = regWrEn && (regAddr == ADDR_MATCH) && cfgEnhanced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) delayReg <= '0;
    else if (wrHit) delayReg <= regWrData[DLY_MSB:DLY_LSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) holdCnt <= '0;
    else if (strobe.loadHold) holdCnt <= delayReg;
    else if (strobe.decHold && holdCnt != '0) holdCnt <= holdCnt - ONE;
  end

  assign delayZero   = (delayReg == '0);
  assign holdLast    = (holdCnt == ONE);
  assign holdNonZero = (holdCnt != '0);

  AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !(regWrEn && cfgEnhanced && regAddr == ADDR_MATCH) |=> $stable(delayReg)); // R8
  AST_LOAD_NOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.loadHold && !delayZero) |=> holdNonZero); // R3
endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
  import rs485_dir_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfgAutoDir,
  input  logic        txBusy,
  input  logic        stopDone,
  input  logic        fifoEmpty,
  input  logic        bitTick,
  input  logic        delayZero,
  input  logic        holdLast,
  input  logic        holdNonZero,
  output holdStrobe_t strobe,
  output logic        dirOn
);
  dirState_e state, stateNxt;

  always_comb begin
    stateNxt        = state;
    strobe.loadHold = 1'b0;
    strobe.decHold  = 1'b0;
    if (!cfgAutoDir) begin
      stateNxt = DIR_IDLE;
    end else begin
      case (state)
        DIR_IDLE: if (txBusy) stateNxt = DIR_TX;
        DIR_TX: begin
          if (stopDone && fifoEmpty) begin
            if (delayZero) stateNxt = DIR_IDLE;
            else begin
              stateNxt        = DIR_HOLD;
              strobe.loadHold = 1'b1;
            end
          end
        end
        DIR_HOLD: begin
          if (txBusy) stateNxt = DIR_TX;
          else if (bitTick) begin
            strobe.decHold = 1'b1;
            if (holdLast) stateNxt = DIR_IDLE;
          end
        end
        default: stateNxt = DIR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= DIR_IDLE;
    else state <= stateNxt;
  end

  assign dirOn = (state != DIR_IDLE);

  AST_TX_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgAutoDir && txBusy) |=> (dirOn || !cfgAutoDir)); // R2
  AST_ZERO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgAutoDir && state == DIR_TX && stopDone && fifoEmpty && delayZero) |=> !dirOn); // R4
  AST_KEEP_ON_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgAutoDir && state == DIR_TX && !fifoEmpty) |=> (dirOn || !cfgAutoDir)); // R5
  AST_HOLD_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgAutoDir && state == DIR_HOLD && txBusy) |=> (state == DIR_TX || !cfgAutoDir)); // R6
  AST_HOLD_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == DIR_HOLD) |-> holdNonZero); // R3
  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgAutoDir |=> !dirOn); // R9
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
  import rs485_dir_pkg::*;
#(
  parameter int DELAY_W  = 4,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  parameter int DLY_ADDR = 6,
  parameter int DLY_LSB  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bitTick,
  input  logic              txBusy,
  input  logic              stopDone,
  input  logic              fifoEmpty,
  input  logic              cfgAutoDir,
  input  logic              cfgEnhanced,
  input  logic              selDtr,
  input  logic              swRts,
  input  logic              swDtr,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic              rtsPin,
  output logic              dtrPin
);
  holdStrobe_t strobe;
  logic delayZero, holdLast, holdNonZero, dirOn;

  rs485_dir_dp #(
    .DELAY_W(DELAY_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .DLY_ADDR(DLY_ADDR), .DLY_LSB(DLY_LSB)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .cfgEnhanced(cfgEnhanced), .strobe(strobe),
    .delayZero(delayZero), .holdLast(holdLast), .holdNonZero(holdNonZero)
  );

  rs485_dir_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .cfgAutoDir(cfgAutoDir), .txBusy(txBusy),
    .stopDone(stopDone), .fifoEmpty(fifoEmpty), .bitTick(bitTick),
    .delayZero(delayZero), .holdLast(holdLast), .holdNonZero(holdNonZero),
    .strobe(strobe), .dirOn(dirOn)
  );

  assign rtsPin = (cfgAutoDir && !selDtr) ? dirOn : swRts;
  assign dtrPin = (cfgAutoDir &&  selDtr) ? dirOn : swDtr;

  AST_ONE_PIN_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgAutoDir && !swRts && !swDtr) |-> !(rtsPin && dtrPin)); // R10
endmodule

// File: tb/rs485_dir_ctrl_tb.sv
module rs485_dir_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bitTick = 0, txBusy = 0, stopDone = 0, fifoEmpty = 1;
  logic cfgAutoDir = 0, cfgEnhanced = 0, selDtr = 0, swRts = 0, swDtr = 0;
  logic regWrEn = 0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic rtsPin, dtrPin;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs485_dir_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bitTick(bitTick), .txBusy(txBusy),
    .stopDone(stopDone), .fifoEmpty(fifoEmpty), .cfgAutoDir(cfgAutoDir),
    .cfgEnhanced(cfgEnhanced), .selDtr(selDtr), .swRts(swRts), .swDtr(swDtr),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .rtsPin(rtsPin), .dtrPin(dtrPin)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic dirPin();
    return selDtr ? dtrPin : rtsPin;
  endfunction

  task automatic writeReg(input logic [2:0] addr, input logic [3:0] dly, input logic enh);
    regWrEn = 1; regAddr = addr; regWrData = {dly, 4'b1011}; cfgEnhanced = enh;
    step();
    regWrEn = 0; cfgEnhanced = 1;
  endtask

  task automatic pulseTick();
    bitTick = 1; step(); bitTick = 0; step();
  endtask

  // Sends one character and ends it with the final stop-bit pulse.
  task automatic sendChar(input logic empty, input string tag);
    txBusy = 1; step();
    chk(dirPin(), 1'b1, {tag, " R2 on"});
    pulseTick();
    chk(dirPin(), 1'b1, {tag, " R3 tick during tx ignored"});
    txBusy = 0; stopDone = 1; fifoEmpty = empty; step();
    stopDone = 0; fifoEmpty = 1;
  endtask

  task automatic checkHold(input int n, input string tag);
    chk(dirPin(), 1'b1, {tag, " R3 hold start"});
    for (int i = 1; i <= n; i++) begin
      pulseTick();
      chk(dirPin(), (i < n) ? 1'b1 : 1'b0, $sformatf("%s R3 tick %0d of %0d", tag, i, n));
    end
  endtask

  task automatic t_reset();
    chk(rtsPin, 1'b0, "R1 rts reset");
    chk(dtrPin, 1'b0, "R1 dtr reset");
    cfgAutoDir = 1; step();
    chk(rtsPin, 1'b0, "R1 idle after enable");
    sendChar(1'b1, "R1 default delay");
    chk(rtsPin, 1'b0, "R1 default delay zero releases");
  endtask

  task automatic t_zero();
    writeReg(3'd6, 4'd0, 1'b1);
    sendChar(1'b1, "R4");
    chk(rtsPin, 1'b0, "R4 release next cycle");
  endtask

  task automatic t_hold();
    writeReg(3'd6, 4'd3, 1'b1);
    sendChar(1'b1, "R7 d3");
    checkHold(3, "R7 d3");
    writeReg(3'd6, 4'd15, 1'b1);
    sendChar(1'b1, "R3 d15");
    checkHold(15, "R3 d15");
  endtask

  task automatic t_queued();
    writeReg(3'd6, 4'd1, 1'b1);
    sendChar(1'b0, "R5");
    for (int i = 0; i < 3; i++) pulseTick();
    chk(rtsPin, 1'b1, "R5 stays on with fifo not empty");
    sendChar(1'b1, "R5 last");
    checkHold(1, "R5 last");
  endtask

  task automatic t_cancel();
    writeReg(3'd6, 4'd2, 1'b1);
    sendChar(1'b1, "R6");
    pulseTick();
    chk(rtsPin, 1'b1, "R6 mid hold");
    sendChar(1'b1, "R6 restart");
    chk(rtsPin, 1'b1, "R6 stays on after cancel");
    checkHold(2, "R6 full hold");
  endtask

  task automatic t_gate();
    writeReg(3'd6, 4'd2, 1'b1);
    writeReg(3'd6, 4'd5, 1'b0);
    writeReg(3'd5, 4'd7, 1'b1);
    sendChar(1'b1, "R8");
    checkHold(2, "R8 delay unchanged");
  endtask

  task automatic t_disabled();
    cfgAutoDir = 0; swRts = 1; swDtr = 0; #1;
    chk(rtsPin, 1'b1, "R9 rts follows sw");
    chk(dtrPin, 1'b0, "R9 dtr follows sw");
    swRts = 0; txBusy = 1; step();
    chk(rtsPin, 1'b0, "R9 tx ignored when disabled");
    cfgAutoDir = 1; step();
    chk(rtsPin, 1'b1, "R9 on after enable");
    cfgAutoDir = 0; txBusy = 0; step();
    cfgAutoDir = 1; #1;
    chk(rtsPin, 1'b0, "R9 disable returned to receive");
  endtask

  task automatic t_select();
    writeReg(3'd6, 4'd1, 1'b1);
    selDtr = 1; swRts = 1; swDtr = 0; #1;
    chk(dtrPin, 1'b0, "R10 dtr idle");
    sendChar(1'b1, "R10 dtr");
    chk(rtsPin, 1'b1, "R10 rts follows sw");
    checkHold(1, "R10 dtr");
    swRts = 0; selDtr = 0; swDtr = 1; #1;
    chk(dtrPin, 1'b1, "R10 dtr follows sw when rts selected");
    swDtr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    t_reset();
    t_zero();
    t_hold();
    t_queued();
    t_cancel();
    t_gate();
    t_disabled();
    t_select();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule